// File: doc/BRIEF.md
# Tagged-Byte Two-Wire Register Loader

This block is a write-only two-wire (I2C) slave. It loads the nine control registers of a multi-function audio processor. It samples the raw SCL and SDA lines on the system clock and cleans them in a synchroniser followed by a glitch filter. From the filtered lines it detects start, stop and clock edges. It answers to one of two chip addresses, selected by an input pin, and acknowledges by pulling SDA low through an open-drain enable. After the address byte, the most significant bit of every byte tags it. A byte with MSB 0 selects a function register (a subaddress). A byte with MSB 1 carries a 7-bit value for the selected register. Any mix of the two may follow within a single transaction.

A selected subaddress stays in force until another subaddress arrives, so any number of data bytes can land in one register. If bit 0 of the subaddress is set, the block enters a looping increment mode. Every data byte then first advances the function index and is written there. The first data byte therefore lands one function past the one that was named. The index wraps from the last function back to the first. Each write raises a one-cycle update strobe for its register. Register values are presented in parallel to the analog control logic.

The controller is one state machine. Its states are `ST_IDLE`, `ST_ADDR` (shifting the address byte), `ST_ADDR_ACK`, `ST_BYTE` (shifting a subaddress or data byte), `ST_BYTE_ACK` and `ST_SKIP` (not addressed). Its transitions are:
- start from any state to `ST_ADDR`;
- stop from any state to `ST_IDLE`;
- `ST_ADDR` to `ST_ADDR_ACK` on the SCL fall after the eighth bit when the address matches, or to `ST_SKIP` when it does not;
- `ST_ADDR_ACK` to `ST_BYTE` on the SCL fall that ends the ninth clock;
- `ST_BYTE` to `ST_BYTE_ACK` on the SCL fall after the eighth bit, where the byte is committed;
- `ST_BYTE_ACK` back to `ST_BYTE` on the SCL fall that ends the ninth clock.

Top module: `tagged_reg_loader`

## Requirements
- R1: A start (SDA falling while SCL is high) restarts address reception from any state, even in the middle of a byte, and discards the partial byte. A stop (SDA rising while SCL is high) returns the block to idle, and it acknowledges nothing until the next start.
- R2: Bytes are 8 bits, MSB first, sampled on SCL rising edges. For every accepted byte, the address byte included, `sda_pull_o` is asserted after the SCL fall that ends bit 8 and released at the SCL fall that ends the ninth clock. It never rises while filtered SCL is high.
- R3: The accepted address byte is 0x80 when `addr_sel_i` is 0 and 0x82 when it is 1, with bit 0 (write) equal to 0. Any other address byte, including the read form, is not acknowledged, and every later byte up to the next start is neither acknowledged nor written.
- R4: After the address, a byte with bit 7 = 0 is a subaddress and a byte with bit 7 = 1 is data. The data value written is byte bits 6:0. Subaddress and data bytes may be mixed in any order and number in one transaction.
- R5: The function index i (0..8) comes from subaddress bits 6:4: bit 6 is i bit 0, bit 5 is i bit 1, bit 4 is i bit 2. When bits 6:4 are all 1, bit 3 chooses index 7 (0) or index 8 (1). The indices are 0 volume, 1 surround/effect, 2 bass, 3 treble, 4 right speaker, 5 left speaker, 6 right aux, 7 left aux, 8 input gain. Register i appears at `regs_o[7*i+6 : 7*i]`.
- R6: Without the increment flag, every data byte goes to the most recently selected register.
- R7: With subaddress bit 0 = 1, each data byte first advances the index (8 wraps to 0) and is written there. The first data byte goes to index+1.
- R8: After reset the registers hold, as 7-bit values by index: 0x7F, 0x7F, 0x0F, 0x0F, 0x1F, 0x1F, 0x7F, 0x7F, 0x00. These are full attenuation with loudness off, surround off with fixed output and full effect cut, bass and treble at −14 dB, and all four attenuators muted.
- R9: Each data write raises exactly one bit of `upd_o`, the bit of the written register, for one cycle, in the cycle its new value appears. Register contents change only in such cycles.
- R10: A start clears the selected subaddress and the increment flag but keeps all register contents. A data byte that arrives before any subaddress in the transaction is acknowledged and discarded.
- R11: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks, after synchronisation, has no effect on reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw two-wire clock line |
| sda_i | input | 1 | Raw two-wire data line (as seen on the wire) |
| addr_sel_i | input | 1 | Chooses chip address 0x80 (0) or 0x82 (1) |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| regs_o | output | 63 | Nine 7-bit function registers, index 0 in the low bits |
| upd_o | output | 9 | One-cycle update strobe per register |

## Verification
The assertions check on every cycle that:
- the glitch filter only follows a synchronised level it has already seen;
- the acknowledge pull-down only starts while SCL is low;
- a start leaves the machine in address reception with no selection, and a stop leaves it idle;
- no write happens without a selected subaddress, and the pointer stays in range;
- at most one update strobe fires, and registers hold still without one.

Whether the right register received the right value can only be shown by the bench. This covers the index decoding, the sticky and looping increment orders with wrap, the address matching for both address-select settings and its neighbours, the abort of a partial byte, and the rejection of short glitches.

// File: rtl/tl_pkg.sv
package tl_pkg;

    localparam int unsigned NREG = 9;
    localparam int unsigned DW   = 7;
    localparam int unsigned IW   = $clog2(NREG);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_BYTE,
        ST_BYTE_ACK,
        ST_SKIP
    } rx_state_t;

    // code = subaddress bits 6:3
    function automatic logic [IW-1:0] tl_decode(input logic [3:0] code);
        logic [2:0] idx;
        idx = {code[1], code[2], code[3]};
        if (idx == 3'd7 && code[0])
            return IW'(8);
        return IW'(idx);
    endfunction

    function automatic logic [IW-1:0] tl_next(input logic [IW-1:0] p);
        return (p == IW'(NREG - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [DW-1:0] tl_reset_val(input int unsigned i);
        case (i)
            0, 1, 6, 7: return 7'h7F;
            2, 3:       return 7'h0F;
            4, 5:       return 7'h1F;
            default:    return 7'h00;
        endcase
    endfunction

endpackage

// File: rtl/tl_line_filter.sv
module tl_line_filter #(
    parameter int unsigned STAGES   = 2,
    parameter int unsigned FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int unsigned CW = $clog2(FILT_LEN + 1);

    logic [STAGES-1:0] sync_q;
    logic [CW-1:0]     cnt_q;
    logic              clean_q;
    logic              s_sync;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= raw_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[STAGES-2:0], raw_i};
            end
        end
    endgenerate

    assign s_sync = sync_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            clean_q <= 1'b1;
        end else if (s_sync == clean_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            clean_q <= s_sync;
            cnt_q   <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign clean_o = clean_q;

    AST_FILTER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean_q) |-> ($past(s_sync) == clean_q)); // R11

endmodule

// File: rtl/tl_bus_events.sv
module tl_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    assign start_o    = scl_f && scl_p && sda_p && !sda_f;
    assign stop_o     = scl_f && scl_p && !sda_p && sda_f;
    assign scl_rise_o = scl_f && !scl_p;
    assign scl_fall_o = !scl_f && scl_p;

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({start_o, stop_o, scl_rise_o, scl_fall_o}) <= 1); // R1

endmodule

// File: rtl/tl_reg_bank.sv
module tl_reg_bank
    import tl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [IW-1:0]      widx_i,
    input  logic [DW-1:0]      wdata_i,
    output logic [NREG*DW-1:0] regs_o,
    output logic [NREG-1:0]    upd_o
);
    logic [DW-1:0]   reg_q [NREG];
    logic [NREG-1:0] upd_q;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    reg_q[g] <= tl_reset_val(g);
                    upd_q[g] <= 1'b0;
                end else begin
                    upd_q[g] <= we_i && (widx_i == IW'(g));
                    if (we_i && (widx_i == IW'(g)))
                        reg_q[g] <= wdata_i;
                end
            end
            assign regs_o[g*DW +: DW] = reg_q[g];
        end
    endgenerate

    assign upd_o = upd_q;

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_o)); // R9
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o == '0) |-> $stable(regs_o)); // R9

endmodule

// File: rtl/tagged_reg_loader.sv
module tagged_reg_loader
    import tl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 3,
    parameter logic [7:0]  BASE_ADDR   = 8'h80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               addr_sel_i,
    output logic               sda_pull_o,
    output logic [NREG*DW-1:0] regs_o,
    output logic [NREG-1:0]    upd_o
);
    logic scl_f, sda_f;
    logic ev_start, ev_stop, ev_rise, ev_fall;

    tl_line_filter #(.STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) i_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .clean_o(scl_f));
    tl_line_filter #(.STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) i_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .clean_o(sda_f));

    tl_bus_events i_events (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .start_o(ev_start), .stop_o(ev_stop),
        .scl_rise_o(ev_rise), .scl_fall_o(ev_fall));

    rx_state_t     state_q, st_d;
    logic [3:0]    bit_cnt_q, cnt_d;
    logic [7:0]    shift_q, sh_d;
    logic          sel_q, sel_d;
    logic          inc_q, inc_d;
    logic [IW-1:0] ptr_q, ptr_d;
    logic          byte_done;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [7:0]    dev_addr;

    assign dev_addr  = {BASE_ADDR[7:2], addr_sel_i, 1'b0};
    assign byte_done = ev_fall && (bit_cnt_q == 4'd8);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            shift_q   <= '0;
            sel_q     <= 1'b0;
            inc_q     <= 1'b0;
            ptr_q     <= '0;
        end else begin
            state_q   <= st_d;
            bit_cnt_q <= cnt_d;
            shift_q   <= sh_d;
            sel_q     <= sel_d;
            inc_q     <= inc_d;
            ptr_q     <= ptr_d;
        end
    end

    // next state and byte commit
    always_comb begin
        st_d   = state_q;
        cnt_d  = bit_cnt_q;
        sh_d   = shift_q;
        sel_d  = sel_q;
        inc_d  = inc_q;
        ptr_d  = ptr_q;
        wr_en  = 1'b0;
        wr_idx = inc_q ? tl_next(ptr_q) : ptr_q;
        if (ev_start) begin
            st_d  = ST_ADDR;
            cnt_d = '0;
            sel_d = 1'b0;
            inc_d = 1'b0;
        end else if (ev_stop) begin
            st_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: ;
                ST_ADDR: begin
                    if (ev_rise && bit_cnt_q < 4'd8) begin
                        sh_d  = {shift_q[6:0], sda_f};
                        cnt_d = bit_cnt_q + 1'b1;
                    end else if (byte_done) begin
                        st_d = (shift_q == dev_addr) ? ST_ADDR_ACK : ST_SKIP;
                    end
                end
                ST_ADDR_ACK, ST_BYTE_ACK: begin
                    if (ev_fall) begin
                        st_d  = ST_BYTE;
                        cnt_d = '0;
                    end
                end
                ST_BYTE: begin
                    if (ev_rise && bit_cnt_q < 4'd8) begin
                        sh_d  = {shift_q[6:0], sda_f};
                        cnt_d = bit_cnt_q + 1'b1;
                    end else if (byte_done) begin
                        st_d = ST_BYTE_ACK;
                        if (!shift_q[7]) begin
                            sel_d = 1'b1;
                            inc_d = shift_q[0];
                            ptr_d = tl_decode(shift_q[6:3]);
                        end else if (sel_q) begin
                            wr_en = 1'b1;
                            ptr_d = wr_idx;
                        end
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_pull_o = (state_q == ST_ADDR_ACK) || (state_q == ST_BYTE_ACK);
    end

    tl_reg_bank i_bank (
        .clk(clk), .rst_n(rst_n), .we_i(wr_en), .widx_i(wr_idx),
        .wdata_i(shift_q[DW-1:0]), .regs_o(regs_o), .upd_o(upd_o));

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_f); // R2
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (state_q == ST_ADDR && !sel_q && !inc_q && bit_cnt_q == 4'd0)); // R10
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (state_q == ST_IDLE && !sda_pull_o)); // R1
    AST_WRITE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (sel_q && state_q == ST_BYTE)); // R10
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q < IW'(NREG)); // R7
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |=> (upd_o == '0)); // R3

endmodule

// File: tb/test_tagged_reg_loader.sv
module test_tagged_reg_loader;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int WATCHDOG   = 190000;
    localparam int NR         = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        addr_sel = 1'b0;
    logic        sda_pull;
    logic [62:0] regs;
    logic [8:0]  upd;
    wire         sda_bus = sda_m & ~sda_pull;

    tagged_reg_loader i_tagged_reg_loader (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_sel_i(addr_sel), .sda_pull_o(sda_pull),
        .regs_o(regs), .upd_o(upd));

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    // bench model
    logic [6:0] exp_reg [NR];
    int         exp_cnt [NR];
    int         seen_cnt [NR];
    int         multi_strobe = 0;
    bit         m_addr_ok, m_sel, m_inc;
    int         m_ptr;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n) begin
            for (int i = 0; i < NR; i++) if (upd[i]) seen_cnt[i]++;
            if ($countones(upd) > 1) multi_strobe++;
        end
    end

    initial begin
        wait (cycles == WATCHDOG);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp=<%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp_v);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [6:0] rst_val(input int i);
        if (i == 2 || i == 3) return 7'h0F;
        if (i == 4 || i == 5) return 7'h1F;
        if (i == 8) return 7'h00;
        return 7'h7F;
    endfunction

    function automatic logic [7:0] sub_byte(input int i, input bit inc);
        logic [7:0] b;
        logic [3:0] ii;
        ii = 4'(i);
        b = 8'h00;
        if (i == 8) b[6:3] = 4'b1111;
        else begin
            b[6] = ii[0]; b[5] = ii[1]; b[4] = ii[2];
        end
        b[0] = inc;
        return b;
    endfunction

    function automatic logic [6:0] reg_of(input int i);
        return regs[i*7 +: 7];
    endfunction

    task automatic bus_start;
        sda_m = 1'b1; wclk(Q);
        scl_m = 1'b1; wclk(2*Q);
        sda_m = 1'b0; wclk(2*Q);
        scl_m = 1'b0; wclk(Q);
        m_sel = 0; m_inc = 0; m_addr_ok = 0;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wclk(Q);
        scl_m = 1'b1; wclk(2*Q);
        sda_m = 1'b1; wclk(2*Q);
        m_addr_ok = 0;
    endtask

    task automatic send_bit(input bit b);
        sda_m = b; wclk(Q);
        scl_m = 1'b1; wclk(2*Q);
        scl_m = 1'b0; wclk(Q);
    endtask

    task automatic send_raw(input logic [7:0] b, output bit acked);
        for (int k = 7; k >= 0; k--) send_bit(b[k]);
        sda_m = 1'b1; wclk(Q);
        scl_m = 1'b1; wclk(Q);
        acked = !sda_bus;
        wclk(Q);
        scl_m = 1'b0; wclk(Q);
    endtask

    // data byte through the model
    task automatic send_tb(input logic [7:0] b, input bit exp_ack, input string req);
        bit a;
        send_raw(b, a);
        chk(a == exp_ack, req, a, exp_ack);
        if (m_addr_ok) begin
            if (!b[7]) begin
                m_sel = 1; m_inc = b[0];
                if (b[6:3] == 4'b1111) m_ptr = 8;
                else m_ptr = b[6] + 2*b[5] + 4*b[4];
            end else if (m_sel) begin
                if (m_inc) m_ptr = (m_ptr + 1) % NR;
                exp_reg[m_ptr] = b[6:0];
                exp_cnt[m_ptr]++;
            end
        end
    endtask

    task automatic send_addr(input logic [7:0] a, input string req);
        bit ack;
        bit exp_ack;
        exp_ack = (a == (8'h80 | {6'b0, addr_sel, 1'b0}));
        send_raw(a, ack);
        chk(ack == exp_ack, req, ack, exp_ack);
        m_addr_ok = exp_ack;
    endtask

    task automatic check_all(input string req);
        wclk(20);
        for (int i = 0; i < NR; i++) chk(reg_of(i) == exp_reg[i], req, reg_of(i), exp_reg[i]);
    endtask

    initial begin
        for (int i = 0; i < NR; i++) begin
            exp_reg[i] = rst_val(i); exp_cnt[i] = 0; seen_cnt[i] = 0;
        end
        m_sel = 0; m_inc = 0; m_ptr = 0; m_addr_ok = 0;
        wclk(5);
        rst_n = 1'b1;
        wclk(10);

        // R8 reset values
        check_all("R8 reset value");
        chk(sda_pull == 1'b0, "R8 idle pull", sda_pull, 0);

        // R3 address sweep: correct address and every single-bit neighbour
        for (int s = 0; s < 2; s++) begin
            addr_sel = 1'(s);
            wclk(5);
            for (int f = -1; f < 8; f++) begin
                logic [7:0] a;
                a = 8'h80 | {6'b0, addr_sel, 1'b0};
                if (f >= 0) a[f] = ~a[f];
                bus_start;
                send_addr(a, "R3 address match");
                // subaddress + data, must be ignored when not addressed
                send_tb(sub_byte(2, 0), m_addr_ok, "R3 byte ack after address");
                send_tb(8'h80 | 8'(7'h40 + 7'(f + 2 + 10*s)), m_addr_ok, "R3 data ack");
                bus_stop;
                check_all("R3 registers after address test");
            end
        end
        addr_sel = 1'b0;

        // R5 R6 R4 sticky sweep over every function
        for (int i = 0; i < NR; i++) begin
            bus_start;
            send_addr(8'h80, "R2 address ack");
            send_tb(sub_byte(i, 0), 1, "R4 subaddress ack");
            send_tb(8'h80 | 8'((i * 13 + 5) & 8'h7F), 1, "R6 data ack");
            send_tb(8'h80 | 8'((i * 29 + 3) & 8'h7F), 1, "R6 data ack");
            bus_stop;
            check_all("R5 R6 sticky write");
        end

        // R7 increment sweep with wrap
        for (int i = 0; i < NR; i++) begin
            bus_start;
            send_addr(8'h80, "R2 address ack");
            send_tb(sub_byte(i, 1), 1, "R7 subaddress ack");
            for (int k = 0; k < 10; k++)
                send_tb(8'h80 | 8'((i * 11 + k * 7 + 1) & 8'h7F), 1, "R7 data ack");
            bus_stop;
            check_all("R7 increment write");
        end

        // R4 mixed subaddresses and data, incl. wrap from 8 to 0
        bus_start;
        send_addr(8'h80, "R2 address ack");
        send_tb(sub_byte(1, 0), 1, "R4 ack");
        send_tb(8'hA5, 1, "R4 ack");
        send_tb(sub_byte(5, 0), 1, "R4 ack");
        send_tb(8'h91, 1, "R4 ack");
        send_tb(8'hE2, 1, "R4 ack");
        send_tb(sub_byte(8, 1), 1, "R4 ack");
        send_tb(8'hB3, 1, "R7 wrap ack");
        bus_stop;
        check_all("R4 mixed transaction");
        chk(reg_of(0) == 7'h33, "R7 wrap 8 to 0", reg_of(0), 7'h33);

        // R10 data before any subaddress is acked and discarded
        bus_start;
        send_addr(8'h80, "R10 address ack");
        send_tb(8'hAA, 1, "R10 unselected data ack");
        bus_stop;
        check_all("R10 registers kept");

        // R1 start inside a byte aborts it
        bus_start;
        send_addr(8'h80, "R1 address ack");
        send_tb(sub_byte(3, 0), 1, "R1 ack");
        for (int k = 0; k < 4; k++) send_bit(1'b1);
        bus_start;
        send_addr(8'h80, "R1 restart address ack");
        send_tb(8'hC4, 1, "R10 data after restart ack");
        send_tb(sub_byte(4, 0), 1, "R1 ack");
        send_tb(8'h8E, 1, "R1 ack");
        bus_stop;
        check_all("R1 abort and restart");

        // R1 after stop, bytes without a start are not acknowledged
        begin
            bit a;
            send_raw(8'h80, a);
            chk(a == 0, "R1 no ack after stop", a, 0);
            send_raw(8'h8F, a);
            chk(a == 0, "R1 no ack after stop", a, 0);
        end
        check_all("R1 registers after stop");

        // R11 short glitches on SCL (while low) and SDA (while SCL high)
        bus_start;
        send_addr(8'h80, "R11 address ack");
        send_tb(sub_byte(6, 0), 1, "R11 ack");
        begin
            logic [7:0] b;
            bit a;
            b = 8'hD6;
            for (int k = 7; k >= 0; k--) begin
                sda_m = b[k]; wclk(Q/2);
                scl_m = 1'b1; wclk(2); scl_m = 1'b0; wclk(Q - Q/2);
                scl_m = 1'b1; wclk(Q);
                if (b[k]) begin
                    sda_m = 1'b0; wclk(2); sda_m = 1'b1; wclk(Q - 2);
                end else wclk(Q);
                scl_m = 1'b0; wclk(Q);
            end
            sda_m = 1'b1; wclk(Q);
            scl_m = 1'b1; wclk(Q);
            a = !sda_bus;
            wclk(Q);
            scl_m = 1'b0; wclk(Q);
            chk(a == 1, "R11 ack of glitched byte", a, 1);
            exp_reg[6] = 7'h56;
            exp_cnt[6]++;
        end
        bus_stop;
        check_all("R11 glitch rejected");

        // R9 strobe counts
        wclk(10);
        for (int i = 0; i < NR; i++)
            chk(seen_cnt[i] == exp_cnt[i], "R9 strobe count", seen_cnt[i], exp_cnt[i]);
        chk(multi_strobe == 0, "R9 one strobe at a time", multi_strobe, 0);
        chk(sda_pull == 1'b0, "R2 pull released at idle", sda_pull, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule